// File: doc/BRIEF.md
# Timer Hold Controller

This block generates hold (freeze) levels for four on-chip timing sources: a watchdog, the master clock of the radio link, a general-purpose software timer and a wake-up timer. Software holds or releases each source by writing a mask to one of two registers. One register adds the sources whose mask bit is 1 to the held set. The other removes them. Both act on a single internal four-bit hold state, so the other sources are not disturbed. A debug-policy bit decides what happens while the processor sits halted in debug. With the bit at 1 every source is held. With the bit at 0 the software hold state applies, except for the watchdog, which is always held during a debug halt.

A mode input from the watchdog interlocks the software hold. While the watchdog runs in its interrupt-instead-of-reset mode, software cannot hold it. A one-bit general status register is stored only so that software can read it back. The four hold outputs are registered. Each one moves exactly one clock after the write or the debug-halt change that caused it, and never glitches between edges. The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure: every write is accepted in the cycle it is presented.

Top module: `tmr_hold_ctl`

## Requirements
- R1: After a synchronous active-low reset, all four hold outputs are 0, the hold state reads back as 0, the debug-policy bit reads 1 and the status bit reads 0.
- R2: A write to byte offset 0x0 adds to the hold state every source whose mask bit is 1, and leaves the other sources unchanged. Hold bit 3 is the watchdog, bit 2 the radio master clock, bit 1 the software timer and bit 0 the wake-up timer.
- R3: A write to byte offset 0x2 removes from the hold state every source whose mask bit is 1, and leaves the other sources unchanged. The bit positions are the same as in R2.
- R4: Bits 15:4 of a write to offset 0x0 or 0x2 have no effect on the hold state or on the outputs.
- R5: While `wdog_nmi_mode` is 1, a write to offset 0x0 with bit 3 set leaves the watchdog hold bit and the `frz_wdog` output unchanged. The other bits of the same write still take effect.
- R6: While `dbg_halted` is 0, each hold output equals its hold-state bit. The output moves on the first clock edge after the write that changes that bit.
- R7: While `dbg_halted` is 1 and the debug-policy bit is 1, all four hold outputs are 1 from the first clock edge after the halt begins.
- R8: While `dbg_halted` is 1 and the debug-policy bit is 0, `frz_wdog` is 1 and the other three outputs equal their hold-state bits.
- R9: A read at offset 0x0 or at offset 0x2 returns the four-bit hold state in bits 3:0, with zeros in bits 15:4.
- R10: A write to offset 0x4 stores bit 0 as the debug-policy bit. A read at offset 0x4 returns that bit in bit 0, with zeros elsewhere.
- R11: A write to offset 0x6 stores bit 0 as the status bit. A read at offset 0x6 returns it in bit 0, with zeros elsewhere. The status bit does not affect the hold outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 3 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| dbg_halted | input | 1 | Processor halted in debug |
| wdog_nmi_mode | input | 1 | Watchdog in interrupt mode; blocks the software hold of the watchdog |
| frz_wdog | output | 1 | Hold level for the watchdog |
| frz_radio | output | 1 | Hold level for the radio master clock |
| frz_swtmr | output | 1 | Hold level for the software timer |
| frz_wakeup | output | 1 | Hold level for the wake-up timer |

## Verification
The bench sweeps all sixteen set masks and all sixteen clear masks, against both a fully held state and an empty one, with the interlock on and off. A design that treated written zeros as releases, or that ignored the interlock, would show a wrong output pattern. It also crosses the debug-halt state with the policy bit and with every hold state. This catches a design that lets the watchdog run during a halt with the policy bit at 0, or that loses the software state when the halt ends. Writes with only reserved bits set, and writes to the status bit, must leave the outputs unchanged. Every output is sampled on the first edge after its cause, so an extra pipeline stage would be reported as a failure.

// File: rtl/tfz_pkg.sv
package tfz_pkg;
  localparam int NSRC   = 4;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  // hold-state bit positions
  localparam int B_WDOG   = 3;
  localparam int B_RADIO  = 2;
  localparam int B_SWTMR  = 1;
  localparam int B_WAKEUP = 0;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFF_SET  = 3'h0;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 3'h2;
  localparam logic [ADDR_W-1:0] OFF_DBG  = 3'h4;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'h6;
endpackage

// File: rtl/tfz_state.sv
module tfz_state
  import tfz_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int W  = REG_W,
  parameter int AW = ADDR_W,
  parameter int WDOG_BIT = B_WDOG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          wdog_nmi_mode,
  output logic [N-1:0]  state_q,
  output logic [N-1:0]  state_d,
  output logic          dbg_en_q,
  output logic          dbg_en_d,
  output logic          status_q
);
  logic         hit_set, hit_clr, hit_dbg, hit_stat;
  logic [N-1:0] set_mask, clr_mask, lock_mask;
  logic         status_d;
  logic         unused_wdata_hi;

  assign hit_set  = wr_en && (addr == OFF_SET);
  assign hit_clr  = wr_en && (addr == OFF_CLR);
  assign hit_dbg  = wr_en && (addr == OFF_DBG);
  assign hit_stat = wr_en && (addr == OFF_STAT);

  // interlock: watchdog may not be held by software in interrupt mode
  generate
    for (genvar i = 0; i < N; i++) begin : g_lock
      if (i == WDOG_BIT) begin : g_wd
        assign lock_mask[i] = ~wdog_nmi_mode;
      end else begin : g_other
        assign lock_mask[i] = 1'b1;
      end
    end
  endgenerate

  assign set_mask = hit_set ? (wdata[N-1:0] & lock_mask) : '0;
  assign clr_mask = hit_clr ? wdata[N-1:0] : '0;
  assign unused_wdata_hi = ^wdata[W-1:N];

  always_comb begin
    // clear wins over set on the same bit
    state_d  = (state_q | set_mask) & ~clr_mask;
    dbg_en_d = hit_dbg  ? wdata[0] : dbg_en_q;
    status_d = hit_stat ? wdata[0] : status_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= '0;
      dbg_en_q <= 1'b1;
      status_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      dbg_en_q <= dbg_en_d;
      status_q <= status_d;
    end
  end

  // R5
  wdog_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_set && wdog_nmi_mode && !state_q[WDOG_BIT]) |=> !state_q[WDOG_BIT]);

  // R3
  clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> ((state_q & $past(wdata[N-1:0])) == '0));

  // R2
  set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_set && !wdog_nmi_mode) |=> ((state_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));
endmodule

// File: rtl/tfz_hold_out.sv
module tfz_hold_out
  import tfz_pkg::*;
#(
  parameter int N = NSRC,
  parameter int WDOG_BIT = B_WDOG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] state_d,
  input  logic         dbg_en_d,
  input  logic         dbg_halted,
  output logic [N-1:0] frz_q
);
  logic [N-1:0] frz_d;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pol
      if (i == WDOG_BIT) begin : g_wd
        assign frz_d[i] = dbg_halted | state_d[i];
      end else begin : g_other
        assign frz_d[i] = (dbg_halted & dbg_en_d) | state_d[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) frz_q <= '0;
    else        frz_q <= frz_d;
  end

  // R7
  dbg_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halted && dbg_en_d) |=> (&frz_q));

  // R8
  dbg_wdog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halted |=> frz_q[WDOG_BIT]);
endmodule

// File: rtl/tfz_rdmux.sv
module tfz_rdmux
  import tfz_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int W  = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  state_q,
  input  logic          dbg_en_q,
  input  logic          status_q,
  output logic [W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_SET, OFF_CLR: rdata[N-1:0] = state_q;
      OFF_DBG:          rdata[0]     = dbg_en_q;
      OFF_STAT:         rdata[0]     = status_q;
      default:          rdata        = '0;
    endcase
  end
endmodule

// File: rtl/tmr_hold_ctl.sv
module tmr_hold_ctl
  import tfz_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int W  = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          dbg_halted,
  input  logic          wdog_nmi_mode,
  output logic          frz_wdog,
  output logic          frz_radio,
  output logic          frz_swtmr,
  output logic          frz_wakeup
);
  logic [N-1:0] state_q, state_d, frz_q;
  logic         dbg_en_q, dbg_en_d, status_q;

  tfz_state #(.N(N), .W(W), .AW(AW), .WDOG_BIT(B_WDOG)) u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wdog_nmi_mode(wdog_nmi_mode), .state_q(state_q), .state_d(state_d),
    .dbg_en_q(dbg_en_q), .dbg_en_d(dbg_en_d), .status_q(status_q)
  );

  tfz_hold_out #(.N(N), .WDOG_BIT(B_WDOG)) u_out (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .dbg_en_d(dbg_en_d),
    .dbg_halted(dbg_halted), .frz_q(frz_q)
  );

  tfz_rdmux #(.N(N), .W(W), .AW(AW)) u_rd (
    .addr(addr), .state_q(state_q), .dbg_en_q(dbg_en_q),
    .status_q(status_q), .rdata(rdata)
  );

  assign frz_wdog   = frz_q[B_WDOG];
  assign frz_radio  = frz_q[B_RADIO];
  assign frz_swtmr  = frz_q[B_SWTMR];
  assign frz_wakeup = frz_q[B_WAKEUP];

  // R6
  run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_halted |=> (frz_q == state_q));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (frz_q == '0 && state_q == '0 && dbg_en_q));
endmodule

// File: tb/tmr_hold_ctl_bench.sv
module tmr_hold_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        dbg_halted = 1'b0;
  logic        wdog_nmi_mode = 1'b0;
  logic        frz_wdog, frz_radio, frz_swtmr, frz_wakeup;

  int checks = 0;
  int fails  = 0;
  logic [3:0] m_state = 4'h0;
  logic       m_dbg   = 1'b1;

  always #10 clk = ~clk;

  tmr_hold_ctl u_tmr_hold_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dbg_halted(dbg_halted), .wdog_nmi_mode(wdog_nmi_mode),
    .frz_wdog(frz_wdog), .frz_radio(frz_radio), .frz_swtmr(frz_swtmr),
    .frz_wakeup(frz_wakeup)
  );

  function automatic logic [3:0] outs();
    return {frz_wdog, frz_radio, frz_swtmr, frz_wakeup};
  endfunction

  function automatic logic [3:0] exp_outs();
    if (!dbg_halted) return m_state;
    if (m_dbg) return 4'hF;
    return m_state | 4'b1000;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a write at a falling edge; on return one rising edge has passed
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 16'h0;
    if (a == 3'h0) m_state = m_state | (d[3:0] & (wdog_nmi_mode ? 4'b0111 : 4'b1111));
    if (a == 3'h2) m_state = m_state & ~d[3:0];
    if (a == 3'h4) m_dbg = d[0];
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 outputs", {12'h0, outs()}, 16'h0);
    rd(3'h0, r); chk("R1 state", r, 16'h0);
    rd(3'h4, r); chk("R1 dbg", r, 16'h1);
    rd(3'h6, r); chk("R1 status", r, 16'h0);

    // R2 R5 R6 R9: every set mask from empty, interlock off and on
    for (int nmi = 0; nmi < 2; nmi++) begin
      wdog_nmi_mode = nmi[0];
      for (int m = 0; m < 16; m++) begin
        wr(3'h2, 16'h000F);
        wr(3'h0, 16'(m));
        chk(nmi ? "R5 set under interlock" : "R2 R6 set", {12'h0, outs()}, {12'h0, exp_outs()});
        rd(3'h0, r); chk("R9 read at set offset", r, {12'h0, m_state});
        rd(3'h2, r); chk("R9 read at clear offset", r, {12'h0, m_state});
      end
    end
    // R5: watchdog already held stays held, set of others still works
    wdog_nmi_mode = 1'b0; wr(3'h0, 16'h0008); wdog_nmi_mode = 1'b1;
    wr(3'h0, 16'h000F);
    chk("R5 other bits still set", {12'h0, outs()}, 16'h000F);
    wdog_nmi_mode = 1'b0;

    // R3: every clear mask from fully held
    for (int m = 0; m < 16; m++) begin
      wr(3'h0, 16'h000F);
      wr(3'h2, 16'(m));
      chk("R3 R6 clear", {12'h0, outs()}, {12'h0, 4'hF & ~4'(m)});
    end

    // R4: reserved bits only
    wr(3'h2, 16'h000F); wr(3'h0, 16'h0005);
    wr(3'h0, 16'hFFF0);
    chk("R4 set reserved", {12'h0, outs()}, 16'h0005);
    wr(3'h2, 16'hFFF0);
    chk("R4 clear reserved", {12'h0, outs()}, 16'h0005);
    rd(3'h0, r); chk("R4 R9 upper zero", r, 16'h0005);

    // R7 R8 R10: halt crossed with policy and every state
    for (int pol = 0; pol < 2; pol++) begin
      wr(3'h4, 16'(pol));
      rd(3'h4, r); chk("R10 dbg read", r, {15'h0, pol[0]});
      for (int m = 0; m < 16; m++) begin
        wr(3'h2, 16'h000F); wr(3'h0, 16'(m));
        @(negedge clk); dbg_halted = 1'b1;
        @(negedge clk);
        chk(pol ? "R7 halt all held" : "R8 halt wdog forced", {12'h0, outs()}, {12'h0, exp_outs()});
        dbg_halted = 1'b0;
        @(negedge clk);
        chk("R6 after halt", {12'h0, outs()}, {12'h0, m_state});
      end
    end
    wr(3'h4, 16'hFFFE);
    rd(3'h4, r); chk("R10 dbg bit0 only", r, 16'h0);

    // R11: status readback, no effect on outputs
    wr(3'h2, 16'h000F); wr(3'h0, 16'h0006);
    wr(3'h6, 16'hFFFF);
    rd(3'h6, r); chk("R11 status set", r, 16'h1);
    chk("R11 outputs unchanged", {12'h0, outs()}, 16'h0006);
    wr(3'h6, 16'h0000);
    rd(3'h6, r); chk("R11 status clear", r, 16'h0);

    // R1: reset restores defaults
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    m_state = 4'h0; m_dbg = 1'b1;
    chk("R1 reset outputs", {12'h0, outs()}, 16'h0);
    rd(3'h4, r); chk("R1 reset dbg", r, 16'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule